// File: doc/BRIEF.md
# Interrupt Event Source Generator

This block turns three kinds of activity into single-clock event pulses that an interrupt controller can route to its interrupt lines. The first is a free-running down-counter that fires every time it reloads from a programmable period. The second watches one pin chosen from a 64-bit pin bus. It reports rising, falling and either-direction transitions. Edge reporting is suspended for a programmable interval after the controller signals that a pin interrupt handler has returned. The third compares a programmable instruction address with the program counter. It fires only on the first clock of an instruction.

Software programs the block through one write port. A two-bit selector chooses which setting the write data updates. The return strobe comes from the interrupt controller when it retires a pin-edge handler. The hold-off keeps a chattering pin from starving the processor.

Top module: `irq_event_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, every pulse output is low.
- R2: After a write of a nonzero period V, the timer pulse rises on the V-th clock edge after the write edge and then every V edges. Each pulse lasts one clock, and a period of 1 gives a pulse on every cycle.
- R3: A period write restarts the count from the new value, with no pulse on the write edge. A period of 0 stops all timer pulses.
- R4: Only the pin addressed by the 6-bit pin selector (bus index 0 to 63) produces edge pulses. Transitions on any other pin have no effect.
- R5: The selected pin passes through two synchronizer flops. A 0-to-1 change pulses the rising and any-edge outputs, and a 1-to-0 change pulses the falling and any-edge outputs. Each pulse lasts one clock and is visible on the third edge after the pin changes.
- R6: If the return strobe is sampled on edge r and the hold-off setting is H, no edge pulse is produced on edges r+1 through r+16·H. Transitions in that window are dropped, not deferred, and a transition due on edge r+16·H+1 is reported.
- R7: A hold-off setting of 0 behaves as 1, giving a window of 16 clocks.
- R8: The breakpoint pulse is high for one clock after an edge where the instruction-start flag is high and the program counter equals the 20-bit breakpoint address. It stays low when the flag is low or the addresses differ.
- R9: The write selector encoding is as follows. Code 0 selects the timer period (32 bits). Code 1 selects the pin selector, which takes data bits 5:0. Code 2 selects the hold-off setting, which takes data bits 15:0. Code 3 selects the breakpoint address, which takes data bits 19:0. Data bits above each field are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting selector (see R9) |
| cfg_wdata | input | 32 | Setting write data |
| pins_i | input | 64 | Pin bus |
| pc_i | input | 20 | Program counter |
| instr_first_i | input | 1 | High on the first clock of each instruction |
| pin_ret_i | input | 1 | Return from pin-edge interrupt handler |
| tmr_pulse_o | output | 1 | Timer reload pulse |
| edge_rise_o | output | 1 | Rising edge pulse |
| edge_fall_o | output | 1 | Falling edge pulse |
| edge_any_o | output | 1 | Either-edge pulse |
| brk_pulse_o | output | 1 | Breakpoint pulse |

## Verification
Each result has a fixed due cycle.
- A timer pulse is due V edges after the period write edge.
- An edge pulse is due three edges after the pin changes: two synchronizer stages and the output register.
- A breakpoint pulse is due one edge after the qualifying cycle.
- Hold-off windows are counted from the edge that samples the return strobe.

The driver stamps every expected pulse with the exact cycle number at which it is due. A monitor at the falling clock edge matches each observed pulse against that stamp. It reports any pulse that is early, late, extra or missing. Transitions that are placed exactly on both sides of each hold-off boundary exercise the inclusive end of the window.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  localparam int unsigned CFG_SEL_W = 2;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_PERIOD = 2'd0,
    SEL_PINSEL = 2'd1,
    SEL_HOLD   = 2'd2,
    SEL_BRK    = 2'd3
  } evt_cfg_sel_e;

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pulse_o
);

  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;

  // next state
  always_comb begin
    period_d = period_q;
    cnt_d    = cnt_q;
    pulse_d  = 1'b0;
    if (wr_en) begin
      period_d = wr_data;
      cnt_d    = wr_data;
    end else if (period_q != '0) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d   = period_q;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
      pulse_q  <= 1'b0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
      pulse_q  <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R3: disabled timer stays silent
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && period_q == '0) |=> !pulse_o);

  // R3: a write never pulses on its own edge
  a_r3_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !pulse_o);

  // R2: pulses are one clock wide for periods above one
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && period_q > CNT_W'(1)) |=> !pulse_o);

endmodule

// File: rtl/evt_pin_edge.sv
module evt_pin_edge #(
  parameter int unsigned PIN_N       = 64,
  parameter int unsigned SEL_W       = 6,
  parameter int unsigned HOLD_W      = 16,
  parameter int unsigned UNIT_LOG2   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_data,
  input  logic              hold_we,
  input  logic [HOLD_W-1:0] hold_data,
  input  logic [PIN_N-1:0]  pins_i,
  input  logic              ret_i,
  output logic              rise_o,
  output logic              fall_o,
  output logic              any_o
);

  localparam int unsigned HCNT_W   = HOLD_W + UNIT_LOG2;
  localparam int unsigned MIN_HOLD = 1 << UNIT_LOG2;

  logic [SEL_W-1:0]       sel_q;
  logic [HOLD_W-1:0]      hold_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [HCNT_W-1:0]      hcnt_q, hcnt_d;
  logic                   rise_q, fall_q, any_q;
  logic                   rise_d, fall_d, any_d;
  logic                   picked;
  logic [HOLD_W-1:0]      hold_eff;
  logic [HCNT_W-1:0]      hold_len;
  logic                   blocked;
  logic                   cur;

  assign picked = pins_i[sel_q];

  // settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      hold_q <= '0;
    end else begin
      if (sel_we)  sel_q  <= sel_data;
      if (hold_we) hold_q <= hold_data;
    end
  end

  // synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= picked;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  // next state
  always_comb begin
    hold_eff = (hold_q == '0) ? HOLD_W'(1) : hold_q;
    hold_len = {hold_eff, {UNIT_LOG2{1'b0}}};
    blocked  = (hcnt_q != '0);
    hcnt_d   = hcnt_q;
    if (ret_i)        hcnt_d = hold_len;
    else if (blocked) hcnt_d = hcnt_q - HCNT_W'(1);
    rise_d = cur & ~prev_q & ~blocked;
    fall_d = ~cur & prev_q & ~blocked;
    any_d  = rise_d | fall_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hcnt_q <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      any_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      hcnt_q <= hcnt_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      any_q  <= any_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign any_o  = any_q;

  // R5: a pin cannot rise and fall in the same cycle
  a_r5_rise_fall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));

  // R5: each directional pulse appears on the either-edge output
  a_r5_any_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |-> any_o);

  // R6: the first edge after a return strobe is always suppressed
  a_r6_ret_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_i, 2) |-> !any_o);

  // R7: the hold-off window is never shorter than sixteen clocks
  a_r7_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> (hcnt_q >= HCNT_W'(MIN_HOLD)));

endmodule

// File: rtl/evt_brk.sv
module evt_brk #(
  parameter int unsigned PC_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_data,
  input  logic [PC_W-1:0] pc_i,
  input  logic            first_i,
  output logic            pulse_o
);

  logic [PC_W-1:0] addr_q;
  logic            pulse_q, pulse_d;

  always_comb begin
    pulse_d = first_i && (pc_i == addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_en) addr_q <= wr_data;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R8: no breakpoint outside the first clock of an instruction
  a_r8_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    !first_i |=> !pulse_o);

endmodule

// File: rtl/irq_event_gen.sv
module irq_event_gen
  import irq_evt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TMR_W       = 32,
  parameter int unsigned PIN_N       = 64,
  parameter int unsigned HOLD_W      = 16,
  parameter int unsigned UNIT_LOG2   = 4,
  parameter int unsigned PC_W        = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic [PIN_N-1:0]     pins_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic                 instr_first_i,
  input  logic                 pin_ret_i,
  output logic                 tmr_pulse_o,
  output logic                 edge_rise_o,
  output logic                 edge_fall_o,
  output logic                 edge_any_o,
  output logic                 brk_pulse_o
);

  localparam int unsigned SEL_W = $clog2(PIN_N);

  logic rst_q_n;
  logic we_period, we_pinsel, we_hold, we_brk;

  evt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q_n)
  );

  always_comb begin
    we_period = cfg_we && (evt_cfg_sel_e'(cfg_sel) == SEL_PERIOD);
    we_pinsel = cfg_we && (evt_cfg_sel_e'(cfg_sel) == SEL_PINSEL);
    we_hold   = cfg_we && (evt_cfg_sel_e'(cfg_sel) == SEL_HOLD);
    we_brk    = cfg_we && (evt_cfg_sel_e'(cfg_sel) == SEL_BRK);
  end

  evt_timer #(.CNT_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (we_period),
    .wr_data(cfg_wdata[TMR_W-1:0]),
    .pulse_o(tmr_pulse_o)
  );

  evt_pin_edge #(
    .PIN_N      (PIN_N),
    .SEL_W      (SEL_W),
    .HOLD_W     (HOLD_W),
    .UNIT_LOG2  (UNIT_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pin (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sel_we   (we_pinsel),
    .sel_data (cfg_wdata[SEL_W-1:0]),
    .hold_we  (we_hold),
    .hold_data(cfg_wdata[HOLD_W-1:0]),
    .pins_i   (pins_i),
    .ret_i    (pin_ret_i),
    .rise_o   (edge_rise_o),
    .fall_o   (edge_fall_o),
    .any_o    (edge_any_o)
  );

  evt_brk #(.PC_W(PC_W)) u_brk (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (we_brk),
    .wr_data(cfg_wdata[PC_W-1:0]),
    .pc_i   (pc_i),
    .first_i(instr_first_i),
    .pulse_o(brk_pulse_o)
  );

  // R1: outputs held low while the internal reset is active
  always @(posedge clk) begin
    if (!rst_q_n) begin
      a_r1_reset_quiet: assert (!(tmr_pulse_o || edge_rise_o || edge_fall_o ||
                                  edge_any_o || brk_pulse_o));
    end
  end

endmodule

// File: tb/irq_event_gen_bench.sv
`timescale 1ns/1ps
module irq_event_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [63:0] pins;
  logic [19:0] pc;
  logic        first;
  logic        pin_ret;
  logic        tmr, rise, fall, any_e, brk;

  always #10 clk = ~clk;

  irq_event_gen u_irq_event_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .pins_i       (pins),
    .pc_i         (pc),
    .instr_first_i(first),
    .pin_ret_i    (pin_ret),
    .tmr_pulse_o  (tmr),
    .edge_rise_o  (rise),
    .edge_fall_o  (fall),
    .edge_any_o   (any_e),
    .brk_pulse_o  (brk)
  );

  typedef struct {
    int    at;
    int    sid;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  int    seen[5];
  bit    done = 1'b0;
  string sname[5] = '{"timer", "rise", "fall", "any", "brk"};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input bit ok, input string what,
                     input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic expect_at(input int sid, input int at, input string req);
    exp_t e;
    e.at = at; e.sid = sid; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare observed pulses with stamped expectations
  initial begin
    for (int s = 0; s < 5; s++) seen[s] = 0;
    forever begin
      logic [4:0] obs;
      @(negedge clk);
      obs = {brk, any_e, fall, rise, tmr};
      for (int s = 0; s < 5; s++) begin
        if (obs[s]) begin
          int idx;
          idx = -1;
          seen[s]++;
          for (int i = 0; i < sb.size(); i++)
            if (idx < 0 && sb[i].sid == s && sb[i].at == cyc) idx = i;
          if (idx >= 0) begin
            chk(sb[idx].req, 1'b1, sname[s], cyc, cyc);
            sb.delete(idx);
          end else begin
            chk("R1..R9 unexpected", 1'b0, sname[s], cyc, -1);
          end
        end
      end
      begin
        int i;
        i = 0;
        while (i < sb.size()) begin
          if (sb[i].at <= cyc) begin
            chk(sb[i].req, 1'b0, {sname[sb[i].sid], " missed"}, -1, sb[i].at);
            sb.delete(i);
          end else begin
            i++;
          end
        end
      end
    end
  end

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic do_write(input logic [1:0] sel, input logic [31:0] d, output int wedge);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    wedge = cyc + 1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic ret_strobe(output int r);
    pin_ret = 1'b1;
    r = cyc + 1;
    @(negedge clk);
    pin_ret = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int w, w2, r, p, snap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    pins = '0; pc = '0; first = 1'b0; pin_ret = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {tmr, rise, fall, any_e, brk} == 5'b0, "outputs in reset",
        int'({tmr, rise, fall, any_e, brk}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {tmr, rise, fall, any_e, brk} == 5'b0, "outputs after reset",
        int'({tmr, rise, fall, any_e, brk}), 0);

    // R2: period 7, four pulses, then stop (R3)
    snap = seen[0];
    do_write(2'd0, 32'd7, w);
    for (int k = 1; k <= 4; k++) expect_at(0, w + 7 * k, "R2");
    wait_to(w + 28);
    do_write(2'd0, 32'd0, w2);
    chk("R2", seen[0] - snap == 4, "timer pulse count", seen[0] - snap, 4);
    snap = seen[0];
    repeat (30) @(negedge clk);
    chk("R3", seen[0] == snap, "timer silent at period 0", seen[0] - snap, 0);

    // R2: period 1 gives every cycle
    do_write(2'd0, 32'd1, w);
    for (int k = 1; k <= 5; k++) expect_at(0, w + k, "R2");
    wait_to(w + 5);
    do_write(2'd0, 32'd0, w2);
    repeat (5) @(negedge clk);

    // R3: rewriting the period restarts the count
    do_write(2'd0, 32'd6, w);
    repeat (3) @(negedge clk);
    do_write(2'd0, 32'd5, w2);
    expect_at(0, w2 + 5, "R3");
    expect_at(0, w2 + 10, "R3");
    wait_to(w2 + 10);
    do_write(2'd0, 32'd0, w);
    repeat (10) @(negedge clk);

    // R9 + R5: select pin 5 with junk in upper data bits
    do_write(2'd1, 32'hFFFF_FFC5, w);
    repeat (5) @(negedge clk);
    p = cyc; pins[5] = 1'b1;
    expect_at(1, p + 3, "R5"); expect_at(3, p + 3, "R5");
    @(negedge clk);
    pins[5] = 1'b0;
    expect_at(2, p + 4, "R5"); expect_at(3, p + 4, "R5");
    repeat (8) @(negedge clk);

    // R4: unselected pin has no effect
    snap = seen[3];
    pins[6] = 1'b1;
    repeat (6) @(negedge clk);
    pins[6] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", seen[3] == snap, "unselected pin edges", seen[3] - snap, 0);

    // R4: highest pin index
    do_write(2'd1, 32'd63, w);
    repeat (5) @(negedge clk);
    p = cyc; pins[63] = 1'b1;
    expect_at(1, p + 3, "R4"); expect_at(3, p + 3, "R4");
    repeat (6) @(negedge clk);
    p = cyc; pins[63] = 1'b0;
    expect_at(2, p + 3, "R4"); expect_at(3, p + 3, "R4");
    repeat (6) @(negedge clk);

    // R6 + R9: hold-off of 2 units (32 clocks), junk upper bits
    do_write(2'd2, 32'hABCD_0002, w);
    repeat (3) @(negedge clk);
    snap = seen[1];
    ret_strobe(r);
    wait_to(r + 29);
    pins[63] = 1'b1;                 // pulse due on r+32: dropped
    @(negedge clk);
    pins[63] = 1'b0;                 // pulse due on r+33: reported
    expect_at(2, r + 33, "R6"); expect_at(3, r + 33, "R6");
    wait_to(r + 40);
    chk("R6", seen[1] == snap, "rise inside hold-off", seen[1] - snap, 0);

    // R7: hold-off 0 acts as 16 clocks
    do_write(2'd2, 32'd0, w);
    repeat (3) @(negedge clk);
    snap = seen[1];
    ret_strobe(r);
    wait_to(r + 13);
    pins[63] = 1'b1;                 // due r+16: dropped
    @(negedge clk);
    pins[63] = 1'b0;                 // due r+17: reported
    expect_at(2, r + 17, "R7"); expect_at(3, r + 17, "R7");
    wait_to(r + 24);
    chk("R7", seen[1] == snap, "rise inside minimum hold-off", seen[1] - snap, 0);

    // R8 + R9: breakpoint at 0x12345, junk upper bits
    do_write(2'd3, 32'hFFF1_2345, w);
    repeat (2) @(negedge clk);
    snap = seen[4];
    pc = 20'h12345; first = 1'b1;
    expect_at(4, cyc + 1, "R8");
    @(negedge clk);
    pc = 20'h12346;                  // mismatch
    @(negedge clk);
    pc = 20'h12345; first = 1'b0;    // not first clock
    @(negedge clk);
    first = 1'b1;
    expect_at(4, cyc + 1, "R8");
    @(negedge clk);
    first = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", seen[4] - snap == 2, "breakpoint pulse count", seen[4] - snap, 2);

    repeat (10) @(negedge clk);
    chk("R2", sb.size() == 0, "outstanding expectations", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule